// File: doc/BRIEF.md
# BCD Calendar Counter with Carry Flag

This block is the timekeeping core of a real-time clock. A 64 Hz tick enable drives a sub-second prescaler. Each prescaler wrap advances a chain of packed-BCD counters: seconds, minutes, hours, weekday, day of month, month, and a four-digit year. The year keeps its century in the upper byte. All of these counters appear as 16-bit registers on a byte-addressed host port. Two control registers select the counting state and handle the carry notification.

A host reads the time as several separate register reads, and the count can roll over between them. To detect this, every seconds carry sets a sticky carry flag. The host clears the flag, reads the time registers, and then checks the flag. If the flag is set again, the host reads the time again. When its enable bit is set, the flag also drives an interrupt line. To set the time, the host stops the count, writes the counter registers, and starts the count again.

Top module: `rtc_calendar`

## Requirements
- R1: Register index n sits at byte address 2n and is accessed only at even addresses; an odd address reads 0 and ignores writes. Index 0 returns the prescaler in bits 5:0. Indices 1 to 7 return seconds, minutes, hours, weekday (bits 2:0), day of month, month and year, all in packed BCD.
- R2: After reset, the time reads 00:00:00, weekday 0, day 01, month 01 and year 0x2000, and both control registers read 0, so the interrupt line is low.
- R3: The count advances by one prescaler step per tick only while control register 2 (index 15) has bit 3 (clock enable) and bit 0 (start) set and bit 1 (prescaler reset) clear. Every 64th step wraps the prescaler and adds one second.
- R4: Seconds and minutes roll from 59 to 00, and hours from 23 to 00. Each rollover carries into the next field, and every BCD digit stays in the range 0 to 9.
- R5: The weekday counts 0 to 6 and advances together with the day of month, wrapping from 6 to 0.
- R6: The day of month wraps to 01 after 31 in months 1, 3, 5, 7, 8, 10 and 12, and after 30 in months 4, 6, 9 and 11. In February it wraps after 28, or after 29 when the year's low two digits are divisible by 4.
- R7: The month wraps from 12 to 01 and then increments the year. The year's low byte wraps from 99 to 00 and carries into the century in bits 15:8.
- R8: Host writes to indices 0 to 7 load the counter only while counting is not running. While it is running, such writes leave the register unchanged.
- R9: While prescaler reset is set, the prescaler is held at 0 and no seconds carry is produced.
- R10: Control register 1 (index 14) bit 7 is set on every seconds carry. Writing 0 to that bit clears it, and writing 1 leaves it unchanged. If a carry and a clearing write fall in the same cycle, the flag ends up set.
- R11: The carry interrupt is high exactly while the carry flag and control register 1 bit 4 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick64 | input | 1 | One-cycle pulse at 64 Hz from the oscillator divider |
| wrEn | input | 1 | Write strobe for the register at addr |
| addr | input | 5 | Byte address of the accessed register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data of the register at addr |
| carryIrq | output | 1 | Carry interrupt request |

## Verification
On every cycle, the embedded assertions check three things. Each seconds carry must set the flag in the next cycle. The flag must persist unless a clearing write arrives. The time fields must stay still while neither an advance nor a load is happening. They also check that the prescaler is cleared under its reset bit and that the month stays within 1 to 12 while the calendar runs. The actual rollover values are shown only by the bench's scenarios: the 30-day and 31-day month ends, February in leap and common years, the year and century carries, and the BCD digit carries. The same holds for ignored writes while running and the flag-clearing protocol seen through the register port.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic adv;      // one prescaler step this cycle
    logic psClear;  // hold prescaler at zero
    logic load;     // host write to a time register
  } dpStrobeT;

  typedef struct packed {
    logic flagBit;
    logic cieBit;
    logic enBit;
    logic psrBit;
    logic startBit;
  } ctrlWrT;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leapYear(input logic tensOdd, input logic [3:0] ones);
    if (tensOdd) return (ones == 4'd2) || (ones == 4'd6);
    return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      8'h02:                      return leap ? 8'h29 : 8'h28;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  ctrlWrT           wrBits,
  input  logic             secCarry,
  output dpStrobeT         strobe,
  output logic             carryFlag,
  output logic             carryIe,
  output logic             clkEn,
  output logic             psReset,
  output logic             runStart,
  output logic             carryIrq
);
  localparam logic [IDX_W-1:0] CTRL1_IDX = IDX_W'(14);
  localparam logic [IDX_W-1:0] CTRL2_IDX = IDX_W'(15);
  localparam int               TIME_REGS = 8;

  logic wrCtrl1, wrCtrl2, running;

  assign wrCtrl1 = wrEn && (wrIdx == CTRL1_IDX);
  assign wrCtrl2 = wrEn && (wrIdx == CTRL2_IDX);
  assign running = clkEn && runStart;

  always_comb begin
    strobe.adv     = tick && running && !psReset;
    strobe.psClear = psReset;
    strobe.load    = wrEn && !running && (int'(wrIdx) < TIME_REGS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
      carryIe   <= 1'b0;
      clkEn     <= 1'b0;
      psReset   <= 1'b0;
      runStart  <= 1'b0;
    end else begin
      if (wrCtrl1) carryIe <= wrBits.cieBit;
      if (secCarry)                          carryFlag <= 1'b1;
      else if (wrCtrl1 && !wrBits.flagBit)   carryFlag <= 1'b0;
      if (wrCtrl2) begin
        clkEn    <= wrBits.enBit;
        psReset  <= wrBits.psrBit;
        runStart <= wrBits.startBit;
      end
    end
  end

  assign carryIrq = carryFlag && carryIe;

  // R10: a seconds carry is always recorded in the flag
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    secCarry |=> carryFlag);

  // R10: only a zero written to bit 7 may drop the flag
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (carryFlag && !(wrCtrl1 && !wrBits.flagBit)) |=> carryFlag);

  // R3: no advance is issued while prescaler reset is held
  p_no_adv_in_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    psReset |-> !strobe.adv);

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int PS_BITS = 6,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobeT           strobe,
  input  logic [2:0]         loadIdx,
  input  logic [DATA_W-1:0]  loadData,
  output logic [PS_BITS-1:0] subSec,
  output logic [7:0]         sec,
  output logic [7:0]         min,
  output logic [7:0]         hour,
  output logic [2:0]         wday,
  output logic [7:0]         mday,
  output logic [7:0]         mon,
  output logic [15:0]        year,
  output logic               secCarry
);
  localparam logic [PS_BITS-1:0] PS_MAX = {PS_BITS{1'b1}};

  logic minCarry, hourCarry, dayCarry, monCarry, yearCarry, centCarry;
  logic [7:0] dayLimit;

  assign dayLimit  = lastDay(mon, leapYear(year[4], year[3:0]));
  assign secCarry  = strobe.adv && (subSec == PS_MAX);
  assign minCarry  = secCarry  && (sec  == 8'h59);
  assign hourCarry = minCarry  && (min  == 8'h59);
  assign dayCarry  = hourCarry && (hour == 8'h23);
  assign monCarry  = dayCarry  && (mday == dayLimit);
  assign yearCarry = monCarry  && (mon  == 8'h12);
  assign centCarry = yearCarry && (year[7:0] == 8'h99);

  function automatic logic hit(input logic ld, input logic [2:0] idx, input int n);
    return ld && (int'(idx) == n);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subSec <= '0;
      sec    <= 8'h00;
      min    <= 8'h00;
      hour   <= 8'h00;
      wday   <= 3'd0;
      mday   <= 8'h01;
      mon    <= 8'h01;
      year   <= 16'h2000;
    end else begin
      if (strobe.psClear)             subSec <= '0;
      else if (hit(strobe.load, loadIdx, 0)) subSec <= loadData[PS_BITS-1:0];
      else if (strobe.adv)            subSec <= subSec + 1'b1;

      if (hit(strobe.load, loadIdx, 1)) sec <= loadData[7:0];
      else if (secCarry) sec <= minCarry ? 8'h00 : bcdInc(sec);

      if (hit(strobe.load, loadIdx, 2)) min <= loadData[7:0];
      else if (minCarry) min <= hourCarry ? 8'h00 : bcdInc(min);

      if (hit(strobe.load, loadIdx, 3)) hour <= loadData[7:0];
      else if (hourCarry) hour <= dayCarry ? 8'h00 : bcdInc(hour);

      if (hit(strobe.load, loadIdx, 4)) wday <= loadData[2:0];
      else if (dayCarry) wday <= (wday == 3'd6) ? 3'd0 : wday + 3'd1;

      if (hit(strobe.load, loadIdx, 5)) mday <= loadData[7:0];
      else if (dayCarry) mday <= monCarry ? 8'h01 : bcdInc(mday);

      if (hit(strobe.load, loadIdx, 6)) mon <= loadData[7:0];
      else if (monCarry) mon <= yearCarry ? 8'h01 : bcdInc(mon);

      if (hit(strobe.load, loadIdx, 7)) year <= loadData[15:0];
      else if (yearCarry) begin
        year[7:0]  <= centCarry ? 8'h00 : bcdInc(year[7:0]);
        if (centCarry) year[15:8] <= (year[15:8] == 8'h99) ? 8'h00 : bcdInc(year[15:8]);
      end
    end
  end

  // R8: time fields only move on an advance or a host load
  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.adv && !strobe.load) |=> $stable({sec, min, hour, wday, mday, mon, year}));

  // R9: prescaler reset leaves the prescaler at zero
  p_ps_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.psClear |=> (subSec == '0));

  // R7: a running calendar keeps a legal month
  p_month_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.adv && mon >= 8'h01 && mon <= 8'h12) |=> (mon >= 8'h01 && mon <= 8'h12));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PS_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick64,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              carryIrq
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0]   idx;
  logic               aligned, wrOk;
  dpStrobeT           strobe;
  ctrlWrT             wrBits;
  logic [PS_BITS-1:0] subSec;
  logic [7:0]         sec, min, hour, mday, mon;
  logic [2:0]         wday;
  logic [15:0]        year;
  logic               secCarry, carryFlag, carryIe, clkEn, psReset, runStart;

  assign idx     = addr[ADDR_W-1:1];
  assign aligned = !addr[0];
  assign wrOk    = wrEn && aligned;
  assign wrBits  = '{flagBit: wrData[7], cieBit: wrData[4], enBit: wrData[3],
                     psrBit: wrData[1], startBit: wrData[0]};

  rtc_cal_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick64), .wrEn(wrOk), .wrIdx(idx),
    .wrBits(wrBits), .secCarry(secCarry), .strobe(strobe),
    .carryFlag(carryFlag), .carryIe(carryIe), .clkEn(clkEn),
    .psReset(psReset), .runStart(runStart), .carryIrq(carryIrq)
  );

  rtc_cal_datapath #(.PS_BITS(PS_BITS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadIdx(idx[2:0]),
    .loadData(wrData), .subSec(subSec), .sec(sec), .min(min), .hour(hour),
    .wday(wday), .mday(mday), .mon(mon), .year(year), .secCarry(secCarry)
  );

  always_comb begin
    rdData = '0;
    if (aligned) begin
      case (int'(idx))
        0:  rdData = DATA_W'(subSec);
        1:  rdData = DATA_W'(sec);
        2:  rdData = DATA_W'(min);
        3:  rdData = DATA_W'(hour);
        4:  rdData = DATA_W'(wday);
        5:  rdData = DATA_W'(mday);
        6:  rdData = DATA_W'(mon);
        7:  rdData = DATA_W'(year);
        14: rdData = DATA_W'({carryFlag, 2'b00, carryIe, 4'b0000});
        15: rdData = DATA_W'({clkEn, 1'b0, psReset, runStart});
        default: rdData = '0;
      endcase
    end
  end

  // R11: interrupt never asserts without a pending flag
  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    carryIrq |-> carryFlag);

endmodule

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick64 = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        carryIrq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk(clk), .rstN(rstN), .tick64(tick64), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .carryIrq(carryIrq)
  );

  typedef struct packed {
    logic [7:0]  sec, min, hr;
    logic [2:0]  wd;
    logic [7:0]  md, mo;
    logic [15:0] yr;
  } calT;
  typedef struct packed { calT ini; calT fin; } vecT;

  localparam int NV = 8;
  localparam vecT VECS [NV] = '{
    // R4 seconds into minutes
    '{'{8'h59,8'h00,8'h00,3'd3,8'h15,8'h06,16'h2023}, '{8'h00,8'h01,8'h00,3'd3,8'h15,8'h06,16'h2023}},
    // R4 BCD digit carry within seconds
    '{'{8'h09,8'h19,8'h09,3'd1,8'h02,8'h03,16'h2023}, '{8'h10,8'h19,8'h09,3'd1,8'h02,8'h03,16'h2023}},
    // R4 hour digit carry
    '{'{8'h59,8'h59,8'h09,3'd1,8'h02,8'h03,16'h2023}, '{8'h00,8'h00,8'h10,3'd1,8'h02,8'h03,16'h2023}},
    // R5 R6 30-day month, weekday 6 -> 0
    '{'{8'h59,8'h59,8'h23,3'd6,8'h30,8'h04,16'h2023}, '{8'h00,8'h00,8'h00,3'd0,8'h01,8'h05,16'h2023}},
    // R6 February, common year
    '{'{8'h59,8'h59,8'h23,3'd2,8'h28,8'h02,16'h2023}, '{8'h00,8'h00,8'h00,3'd3,8'h01,8'h03,16'h2023}},
    // R6 February, leap year
    '{'{8'h59,8'h59,8'h23,3'd2,8'h28,8'h02,16'h2024}, '{8'h00,8'h00,8'h00,3'd3,8'h29,8'h02,16'h2024}},
    // R6 31-day month
    '{'{8'h59,8'h59,8'h23,3'd4,8'h31,8'h01,16'h2025}, '{8'h00,8'h00,8'h00,3'd5,8'h01,8'h02,16'h2025}},
    // R7 year end with century carry
    '{'{8'h59,8'h59,8'h23,3'd1,8'h31,8'h12,16'h2099}, '{8'h00,8'h00,8'h00,3'd2,8'h01,8'h01,16'h2100}}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int idx, input logic [15:0] d);
    @(negedge clk);
    addr = 5'(idx * 2); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input int idx, output logic [15:0] d);
    @(negedge clk);
    addr = 5'(idx * 2);
    #1 d = rdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick64 = 1'b1;
      @(negedge clk); tick64 = 1'b0;
    end
  endtask

  task automatic runAll();
    logic [15:0] v, prev;
    // R2 reset state
    busRead(0, v); check("R2 prescaler", v, 16'h0000);
    busRead(1, v); check("R2 sec", v, 16'h0000);
    busRead(3, v); check("R2 hour", v, 16'h0000);
    busRead(4, v); check("R2 weekday", v, 16'h0000);
    busRead(5, v); check("R2 mday", v, 16'h0001);
    busRead(6, v); check("R2 month", v, 16'h0001);
    busRead(7, v); check("R2 year", v, 16'h2000);
    busRead(14, v); check("R2 ctrl1", v, 16'h0000);
    busRead(15, v); check("R2 ctrl2", v, 16'h0000);
    check("R2 irq", {15'd0, carryIrq}, 16'h0000);

    // R3 no counting while stopped or disabled
    busWrite(15, 16'h0008); ticks(4);
    busRead(0, v); check("R3 start clear", v, 16'h0000);
    busWrite(15, 16'h0001); ticks(4);
    busRead(0, v); check("R3 enable clear", v, 16'h0000);
    busWrite(15, 16'h0009); ticks(5);
    busRead(0, v); check("R3 R1 prescaler steps", v, 16'h0005);

    // R9 prescaler reset
    busWrite(15, 16'h000B); ticks(2);
    busRead(0, v); check("R9 prescaler held", v, 16'h0000);
    busWrite(15, 16'h0009); ticks(3);
    busRead(0, v); check("R9 resumes", v, 16'h0003);

    // R8 writes ignored while running
    busRead(1, prev);
    busWrite(1, 16'h0033);
    busRead(1, v); check("R8 write while running", v, prev);

    // R1 odd address reads zero and ignores writes
    busWrite(15, 16'h0008);
    busWrite(1, 16'h0042);
    @(negedge clk); addr = 5'd3; #1 check("R1 odd read", rdData, 16'h0000);
    @(negedge clk); addr = 5'd3; wrData = 16'h0011; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    busRead(1, v); check("R1 odd write ignored", v, 16'h0042);

    // Vector table: one second of counting from each start state
    for (int k = 0; k < NV; k++) begin
      busWrite(15, 16'h0008);
      busWrite(0, 16'h0000);
      busWrite(1, {8'h00, VECS[k].ini.sec});
      busWrite(2, {8'h00, VECS[k].ini.min});
      busWrite(3, {8'h00, VECS[k].ini.hr});
      busWrite(4, {13'd0, VECS[k].ini.wd});
      busWrite(5, {8'h00, VECS[k].ini.md});
      busWrite(6, {8'h00, VECS[k].ini.mo});
      busWrite(7, VECS[k].ini.yr);
      busWrite(14, 16'h0000);
      busWrite(15, 16'h0009);
      ticks(63);
      busRead(14, v); check("R10 no flag before carry", v, 16'h0000);
      ticks(1);
      busRead(1, v); check("R4 sec", v, {8'h00, VECS[k].fin.sec});
      busRead(2, v); check("R4 min", v, {8'h00, VECS[k].fin.min});
      busRead(3, v); check("R4 hour", v, {8'h00, VECS[k].fin.hr});
      busRead(4, v); check("R5 weekday", v, {13'd0, VECS[k].fin.wd});
      busRead(5, v); check("R6 mday", v, {8'h00, VECS[k].fin.md});
      busRead(6, v); check("R7 month", v, {8'h00, VECS[k].fin.mo});
      busRead(7, v); check("R7 year", v, VECS[k].fin.yr);
      busRead(14, v); check("R10 flag after carry", v, 16'h0080);
    end

    // R10 R11 flag clearing and interrupt enable
    busWrite(15, 16'h0008);
    busWrite(14, 16'h0090);
    busRead(14, v); check("R10 write one keeps flag", v, 16'h0090);
    check("R11 irq high", {15'd0, carryIrq}, 16'h0001);
    busWrite(14, 16'h0080);
    check("R11 irq masked", {15'd0, carryIrq}, 16'h0000);
    busRead(14, v); check("R10 flag still set", v, 16'h0080);
    busWrite(14, 16'h0010);
    busRead(14, v); check("R10 write zero clears", v, 16'h0010);
    check("R11 irq without flag", {15'd0, carryIrq}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule